// File: doc/BRIEF.md
# Zero-Run Violation Marker for HDB3 Encoding

This block is the first stage of an HDB3 line encoder. It takes a serial NRZ stream, one bit per clock, qualified by a valid strobe. For each valid bit it produces a 2-bit symbol tag. A one is tagged as a mark. A zero is tagged as a plain zero. The zero that completes a run of `RUN_LEN` consecutive zeros (four by default) is tagged as a violation. Later stages read these tags to insert balancing pulses and assign polarity. This block chooses no polarity.

The run counter advances only on valid zero bits. It restarts on a valid one and directly after a violation is tagged. A long run of zeros is therefore cut into successive groups, each of which ends in a violation. Idle cycles, where the strobe is low, leave the count unchanged. Each output is registered once, so every tag appears exactly one clock after the bit that caused it. A parameter selects whether the run counter is built as a binary counter or as a one-hot shift chain.

Top module: `hdb3_vmark`

## Requirements
- R1: `out_vld` in each cycle equals the value `in_vld` had at the previous clock edge. Every tag appears one clock after its input bit.
- R2: A valid zero that is the `RUN_LEN`-th consecutive valid zero (four by default) leaves as `out_sym` = 2'b11.
- R3: A valid one leaves as `out_sym` = 2'b01 and restarts the zero count.
- R4: Any other valid zero leaves as `out_sym` = 2'b00. A run shorter than `RUN_LEN` produces only 2'b00 tags.
- R5: The zero count restarts after each violation. A run of 2×`RUN_LEN` zeros yields 2'b11 at its `RUN_LEN`-th and at its last zero, and 2'b00 everywhere else.
- R6: While `out_vld` is low, `out_sym` is 2'b00.
- R7: Cycles with `in_vld` low neither advance nor clear the zero count.
- R8: A synchronous active-high `rst` clears the zero count and drives `out_vld` to 0 and `out_sym` to 2'b00 at the next edge.
- R9: The code 2'b10 never appears on `out_sym`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input bit qualifier |
| in_bit | input | 1 | NRZ data bit |
| out_vld | output | 1 | Output symbol qualifier, one clock behind `in_vld` |
| out_sym | output | 2 | Symbol tag: 00 zero, 01 one, 11 violation |

## Verification
The bench builds two instances with `RUN_LEN` = 4, the line value. One uses the binary counter and the other uses the one-hot chain, and both must match the same expected stream cycle for cycle. Both counter variants are therefore checked on runs of exactly three, four, five and eight zeros, on runs broken by idle gaps, and on a reset that arrives in the middle of a run. Sparse random ones produce long zero runs that cross several group boundaries.

// File: rtl/hdb3vm_pkg.sv
package hdb3vm_pkg;
   localparam int SYM_W = 2;
   typedef enum logic [SYM_W-1:0] {
      SYM_ZERO = 2'b00,
      SYM_ONE  = 2'b01,
      SYM_VIOL = 2'b11
   } sym_e;
endpackage

// File: rtl/hdb3vm_zrun.sv
// Zero-run tracker: flags the input zero that completes a group of RUN_LEN.
module hdb3vm_zrun #(
   parameter int RUN_LEN    = 4,
   parameter bit CNT_ONEHOT = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic in_vld,
   input  logic in_bit,
   output logic run_hit
);
   localparam int CW = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;

   logic zero_in;
   assign zero_in = in_vld & ~in_bit;

   generate
      if (CNT_ONEHOT) begin : g_onehot
         logic [RUN_LEN-1:0] pos_q;
         assign run_hit = zero_in & pos_q[RUN_LEN-1];
         always_ff @(posedge clk) begin
            if (rst) begin
               pos_q <= {{(RUN_LEN-1){1'b0}}, 1'b1};
            end else if (in_vld) begin
               if (in_bit || pos_q[RUN_LEN-1])
                  pos_q <= {{(RUN_LEN-1){1'b0}}, 1'b1};
               else
                  pos_q <= {pos_q[RUN_LEN-2:0], 1'b0};
            end
         end
      end else begin : g_binary
         logic [CW-1:0] cnt_q;
         assign run_hit = zero_in & (cnt_q == CW'(RUN_LEN-1));
         always_ff @(posedge clk) begin
            if (rst) begin
               cnt_q <= '0;
            end else if (in_vld) begin
               if (in_bit || run_hit)
                  cnt_q <= '0;
               else
                  cnt_q <= cnt_q + CW'(1);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/hdb3vm_map.sv
// Symbol selection for the current input bit.
module hdb3vm_map
   import hdb3vm_pkg::*;
(
   input  logic             in_vld,
   input  logic             in_bit,
   input  logic             run_hit,
   output logic [SYM_W-1:0] sym_nxt
);
   always_comb begin
      if (!in_vld)      sym_nxt = SYM_ZERO;
      else if (in_bit)  sym_nxt = SYM_ONE;
      else if (run_hit) sym_nxt = SYM_VIOL;
      else              sym_nxt = SYM_ZERO;
   end
endmodule

// File: rtl/hdb3vm_oreg.sv
// Single output register stage.
module hdb3vm_oreg
   import hdb3vm_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             vld_nxt,
   input  logic [SYM_W-1:0] sym_nxt,
   output logic             vld_q,
   output logic [SYM_W-1:0] sym_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= 1'b0;
         sym_q <= SYM_ZERO;
      end else begin
         vld_q <= vld_nxt;
         sym_q <= sym_nxt;
      end
   end
endmodule

// File: rtl/hdb3_vmark.sv
module hdb3_vmark #(
   parameter int RUN_LEN    = 4,
   parameter bit CNT_ONEHOT = 1'b0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       in_vld,
   input  logic       in_bit,
   output logic       out_vld,
   output logic [1:0] out_sym
);
   initial begin
      assert (RUN_LEN >= 2) else $error("hdb3_vmark: RUN_LEN must be at least 2");
      assert (hdb3vm_pkg::SYM_W == 2) else $error("hdb3_vmark: symbol width must be 2");
   end

   logic       run_hit;
   logic [1:0] sym_nxt;

   hdb3vm_zrun #(.RUN_LEN(RUN_LEN), .CNT_ONEHOT(CNT_ONEHOT)) u_zrun (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_bit(in_bit), .run_hit(run_hit)
   );

   hdb3vm_map u_map (
      .in_vld(in_vld), .in_bit(in_bit), .run_hit(run_hit), .sym_nxt(sym_nxt)
   );

   hdb3vm_oreg u_oreg (
      .clk(clk), .rst(rst), .vld_nxt(in_vld), .sym_nxt(sym_nxt),
      .vld_q(out_vld), .sym_q(out_sym)
   );
endmodule

// File: rtl/hdb3_vmark_chk.sv
module hdb3_vmark_chk #(
   parameter int RUN_LEN = 4
) (
   input logic       clk,
   input logic       rst,
   input logic       in_vld,
   input logic       in_bit,
   input logic       out_vld,
   input logic [1:0] out_sym
);
   localparam int ZW = $clog2(RUN_LEN + 1) + 1;

   // Count of 00 tags seen on the output since the last 01/11 tag.
   logic [ZW-1:0] ozc_q;
   always_ff @(posedge clk) begin
      if (rst) ozc_q <= '0;
      else if (out_vld) begin
         if (out_sym == 2'b00) ozc_q <= ozc_q + ZW'(1);
         else                  ozc_q <= '0;
      end
   end

   AST_VLD_SET:    assert property (@(posedge clk) disable iff (rst) in_vld |=> out_vld);   // R1
   AST_VLD_CLR:    assert property (@(posedge clk) disable iff (rst) !in_vld |=> !out_vld); // R1
   AST_V_AT_RUN:   assert property (@(posedge clk) disable iff (rst)
                      (out_vld && out_sym == 2'b11) |-> ozc_q == ZW'(RUN_LEN-1));         // R2
   AST_ONE_TAG:    assert property (@(posedge clk) disable iff (rst)
                      (in_vld && in_bit) |=> out_sym == 2'b01);                           // R3
   AST_RUN_CAP:    assert property (@(posedge clk) disable iff (rst)
                      (out_vld && out_sym == 2'b00) |-> ozc_q < ZW'(RUN_LEN-1));          // R5
   AST_IDLE_ZERO:  assert property (@(posedge clk) disable iff (rst)
                      !out_vld |-> out_sym == 2'b00);                                     // R6
   AST_RESET_OUT:  assert property (@(posedge clk) rst |=> (!out_vld && out_sym == 2'b00)); // R8
   AST_NO_CODE10:  assert property (@(posedge clk) disable iff (rst) out_sym != 2'b10);    // R9
endmodule

bind hdb3_vmark hdb3_vmark_chk #(.RUN_LEN(RUN_LEN)) u_chk (
   .clk(clk), .rst(rst), .in_vld(in_vld), .in_bit(in_bit),
   .out_vld(out_vld), .out_sym(out_sym)
);

// File: tb/hdb3_vmark_tb.sv
`timescale 1ns/1ps
module hdb3_vmark_tb;
   localparam int RUN_LEN = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_vld = 1'b0;
   logic       in_bit = 1'b0;
   logic       out_vld, out_vld_oh;
   logic [1:0] out_sym, out_sym_oh;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // expected outputs after the next edge
   logic       exp_vld = 1'b0;
   logic [1:0] exp_sym = 2'b00;
   string      exp_tag = "R8";
   int         mdl_zc = 0;

   always #4 clk = ~clk;

   hdb3_vmark #(.RUN_LEN(RUN_LEN), .CNT_ONEHOT(1'b0)) u_dut (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_bit(in_bit),
      .out_vld(out_vld), .out_sym(out_sym)
   );
   hdb3_vmark #(.RUN_LEN(RUN_LEN), .CNT_ONEHOT(1'b1)) u_dut_oh (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_bit(in_bit),
      .out_vld(out_vld_oh), .out_sym(out_sym_oh)
   );

   // Reference: symbol for one input bit, updates run count (R2 R3 R4 R5 R7)
   function automatic logic [1:0] ref_sym(input logic v, input logic b);
      if (!v) return 2'b00;                   // R6, count untouched (R7)
      if (b) begin mdl_zc = 0; return 2'b01; end // R3
      if (mdl_zc == RUN_LEN-1) begin mdl_zc = 0; return 2'b11; end // R2 R5
      mdl_zc++;
      return 2'b00;                           // R4
   endfunction

   function automatic string tag_of(input logic v, input logic [1:0] s);
      if (!v) return "R1 R6 R7";
      case (s)
         2'b11:   return "R2 R5 R9";
         2'b01:   return "R1 R3";
         default: return "R4 R7";
      endcase
   endfunction

   task automatic check_now();
      n_chk++;
      if (out_vld !== exp_vld || out_sym !== exp_sym) begin
         n_fail++;
         $display("FAIL %s binary: vld=%0b sym=%b expected vld=%0b sym=%b",
                  exp_tag, out_vld, out_sym, exp_vld, exp_sym);
      end
      n_chk++;
      if (out_vld_oh !== exp_vld || out_sym_oh !== exp_sym) begin
         n_fail++;
         $display("FAIL %s onehot: vld=%0b sym=%b expected vld=%0b sym=%b",
                  exp_tag, out_vld_oh, out_sym_oh, exp_vld, exp_sym);
      end
   endtask

   task automatic drive(input logic v, input logic b);
      @(negedge clk);
      check_now();
      rst = 1'b0;
      in_vld = v;
      in_bit = b;
      exp_sym = ref_sym(v, b);
      exp_vld = v;
      exp_tag = tag_of(v, exp_sym);
   endtask

   task automatic do_reset();
      @(negedge clk);
      check_now();
      rst = 1'b1;
      in_vld = 1'b1;
      in_bit = 1'b0;
      mdl_zc = 0;
      exp_vld = 1'b0;
      exp_sym = 2'b00;
      exp_tag = "R8";
   endtask

   task automatic zeros(input int n);
      for (int i = 0; i < n; i++) drive(1'b1, 1'b0);
   endtask

   initial begin
      void'($urandom(32'h5EED_0461));
      repeat (2) @(posedge clk);
      // reset state (R8)
      do_reset();
      // run of three: no violation (R4)
      drive(1'b1, 1'b1); zeros(3); drive(1'b1, 1'b1);
      // exactly four: violation on the fourth (R2)
      zeros(4); drive(1'b1, 1'b1);
      // five zeros: violation then a plain zero (R5)
      zeros(5); drive(1'b1, 1'b1);
      // eight zeros: two violations (R5)
      zeros(8);
      // idle gaps inside a run do not break it (R7)
      drive(1'b1, 1'b1);
      drive(1'b1, 1'b0); drive(1'b0, 1'b0); drive(1'b1, 1'b0);
      drive(1'b0, 1'b1); drive(1'b0, 1'b0); drive(1'b1, 1'b0); drive(1'b1, 1'b0);
      drive(1'b0, 1'b0);
      // reset in the middle of a run clears the count (R8)
      zeros(3);
      do_reset();
      zeros(3); drive(1'b1, 1'b1);
      zeros(4);
      // random traffic with sparse ones for long zero runs
      for (int i = 0; i < 3000; i++) begin
         logic v, b;
         v = ($urandom % 8) != 0;
         b = ($urandom % 5) == 0;
         drive(v, b);
      end
      drive(1'b0, 1'b0);
      drive(1'b0, 1'b0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule